// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches the four active-low modem handshake lines of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a two-stage synchronizer. The block then compares the line with its level on the previous cycle. It keeps one sticky flag per line and records in that flag any change since the status byte was last read.

Software reads the status byte, which holds the four flags and the four live levels. A read strobe clears all the flags, but an edge that lands in the clearing cycle is kept. The ring line follows its own rule: only its trailing edge sets its flag, which means the pin returning from low to high. A modem-status interrupt request is raised while the interrupt is enabled and any flag is set. In loopback mode the four lines are taken from the block's own modem-control outputs and the pins are not used.

Top module: `modem_status_det`

## Requirements
- R1: After reset `status_o` reads 8'hF0 and `irq_o` is low.
- R2: `status_o` bits [3:0] are the change flags for CTS, DSR, RI and DCD, in that order. Bits [7:4] are the live levels of the same lines, in the same order.
- R3: A live-level bit equals its pin level: 0 when the line is asserted (low) and 1 when it is de-asserted. A pin change shows in that bit after exactly two rising clock edges.
- R4: On CTS, DSR and DCD, a change in either direction sets that line's flag after exactly three rising clock edges.
- R5: The RI flag is set only by a low-to-high transition of the RI pin (trailing edge of a ring). A high-to-low transition leaves the flag clear.
- R6: A flag stays set until the status is read, whatever the line does meanwhile.
- R7: `status_rd_i` high at a rising edge clears all four flags at that edge. While the strobe is high, `status_o` still shows the flags as they were before the clear.
- R8: If a line's change is detected in the same cycle as the read strobe, that line's flag stays set after the clear.
- R9: `irq_o` is high exactly when `msi_en_i` is high and at least one flag is set.
- R10: With `loop_en_i` high, the lines are taken from the loopback inputs (RTS to CTS, DTR to DSR, OUT1 to RI, OUT2 to DCD). Pin activity then changes neither the levels nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring indicator pin, active low |
| dcd_ni | input | 1 | Carrier detect pin, active low |
| loop_en_i | input | 1 | Loopback select |
| lb_rts_ni | input | 1 | RTS output level, used as CTS in loopback |
| lb_dtr_ni | input | 1 | DTR output level, used as DSR in loopback |
| lb_out1_ni | input | 1 | OUT1 output level, used as RI in loopback |
| lb_out2_ni | input | 1 | OUT2 output level, used as DCD in loopback |
| status_rd_i | input | 1 | Status register read strobe |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| status_o | output | 8 | Flags [3:0], live levels [7:4] |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench drives RI in both directions. A design that flags any RI change would set the flag on assertion, and the check catches that. It places a DCD edge exactly in the clearing cycle of a read. A design that lets the clear win would lose that event. It also checks that the status seen during the read still holds the old flags. Pins are toggled while loopback is selected: a mux wired the wrong way round, or one that swaps lines, would show a level or flag on the wrong bit. Latency is checked at the exact edge, so an extra or a missing synchronizer stage is caught.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NUM_LINES   = 4;
  localparam int SYNC_STAGES = 2;
  localparam int IDX_CTS     = 0;
  localparam int IDX_DSR     = 1;
  localparam int IDX_RI      = 2;
  localparam int IDX_DCD     = 3;
  localparam int STATUS_W    = 2 * NUM_LINES;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;  // idle = de-asserted
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_loop_mux.sv
module mdm_loop_mux #(
  parameter int W = 4
) (
  input  logic         loop_en_i,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] lb_i,
  output logic [W-1:0] sel_o
);
  for (genvar i = 0; i < W; i++) begin : g_line
    assign sel_o[i] = loop_en_i ? lb_i[i] : pin_i[i];
  end
endmodule

// File: rtl/mdm_change_tracker.sv
module mdm_change_tracker #(
  parameter int W      = 4,
  parameter int RI_IDX = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         rd_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] evt;

  for (genvar i = 0; i < W; i++) begin : g_evt
    if (i == RI_IDX) begin : g_trail
      assign evt[i] = ~prev_q[i] & lvl_i[i];  // low -> high only
    end else begin : g_any
      assign evt[i] = prev_q[i] ^ lvl_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= evt | (flag_q & ~{W{rd_i}});  // new event beats clear
    end
  end

  assign flag_o = flag_q;
  assign lvl_o  = lvl_i;

  // R6: sticky without a read
  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[0] && !rd_i) |=> flag_q[0]);
  // R7: read with no new event clears
  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && prev_q[0] == lvl_i[0]) |=> !flag_q[0]);
  // R4: change sets flag on next edge
  a_r4_change_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_q[0] != lvl_i[0]) |=> flag_q[0]);
  // R5: ring leading edge does not set flag
  a_r5_ri_lead_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q[RI_IDX] && prev_q[RI_IDX] && !lvl_i[RI_IDX]) |=> !flag_q[RI_IDX]);
endmodule

// File: rtl/modem_status_det.sv
module modem_status_det
  import mdm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cts_ni,
  input  logic                dsr_ni,
  input  logic                ri_ni,
  input  logic                dcd_ni,
  input  logic                loop_en_i,
  input  logic                lb_rts_ni,
  input  logic                lb_dtr_ni,
  input  logic                lb_out1_ni,
  input  logic                lb_out2_ni,
  input  logic                status_rd_i,
  input  logic                msi_en_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                irq_o
);
  logic [NUM_LINES-1:0] pin_v, lb_v, sel_v, sync_v, flag_v, lvl_v;

  assign pin_v[IDX_CTS] = cts_ni;
  assign pin_v[IDX_DSR] = dsr_ni;
  assign pin_v[IDX_RI]  = ri_ni;
  assign pin_v[IDX_DCD] = dcd_ni;
  assign lb_v[IDX_CTS]  = lb_rts_ni;
  assign lb_v[IDX_DSR]  = lb_dtr_ni;
  assign lb_v[IDX_RI]   = lb_out1_ni;
  assign lb_v[IDX_DCD]  = lb_out2_ni;

  mdm_loop_mux #(.W(NUM_LINES)) u_mux (
    .loop_en_i(loop_en_i), .pin_i(pin_v), .lb_i(lb_v), .sel_o(sel_v)
  );

  mdm_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sel_v), .q_o(sync_v)
  );

  mdm_change_tracker #(.W(NUM_LINES), .RI_IDX(IDX_RI)) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_v), .rd_i(status_rd_i),
    .flag_o(flag_v), .lvl_o(lvl_v)
  );

  assign status_o = {lvl_v, flag_v};
  assign irq_o    = msi_en_i & (|flag_v);

  // R9: no request while disabled
  a_r9_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msi_en_i |-> !irq_o);
endmodule

// File: tb/modem_status_det_bench.sv
module modem_status_det_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic loop_en = 0, lb_rts = 1, lb_dtr = 1, lb_out1 = 1, lb_out2 = 1;
  logic rd = 0, msi_en = 0;
  logic [7:0] status;
  logic irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_det u_modem_status_det (
    .clk_i(clk), .rst_ni(rst_n),
    .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .dcd_ni(dcd_n),
    .loop_en_i(loop_en), .lb_rts_ni(lb_rts), .lb_dtr_ni(lb_dtr),
    .lb_out1_ni(lb_out1), .lb_out2_ni(lb_out2),
    .status_rd_i(rd), .msi_en_i(msi_en),
    .status_o(status), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // read strobe for one cycle; returns status seen during the strobe
  task automatic do_read(output logic [7:0] seen);
    @(negedge clk); rd = 1; seen = status;
    @(negedge clk); rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'hF0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_latency();
    logic [7:0] s;
    @(negedge clk); cts_n = 0;
    @(negedge clk); chk("R3 level not yet", status, 8'hF0);
    @(negedge clk); chk("R3 level after 2 edges", status, 8'hE0);
    @(negedge clk); chk("R4 flag after 3 edges", status, 8'hE1);
    do_read(s);
    chk("R7 seen during read", s, 8'hE1);
    chk("R7 cleared after read", status, 8'hE0);
    cts_n = 1; settle();
    chk("R4 cts rise sets flag", status, 8'hF1);
    do_read(s);
  endtask

  task automatic t_layout();
    logic [7:0] s;
    dsr_n = 0; settle();
    chk("R2 dsr bits", status, 8'hD2);
    dcd_n = 0; settle();
    chk("R2 dcd bits", status, 8'h5A);
    dsr_n = 1; dcd_n = 1; settle();
    chk("R6 still set after return", status, 8'hFA);
    do_read(s);
    chk("R7 all cleared", status, 8'hF0);
  endtask

  task automatic t_ring();
    logic [7:0] s;
    ri_n = 0; settle();
    chk("R5 lead edge ignored", status, 8'hB0);
    ri_n = 1; settle();
    chk("R5 trail edge sets", status, 8'hF4);
    do_read(s);
  endtask

  task automatic t_collide();
    logic [7:0] s;
    cts_n = 0; settle();  // cts flag set
    @(negedge clk); dcd_n = 0;
    @(negedge clk);
    @(negedge clk); rd = 1;  // dcd change detected this cycle
    @(negedge clk); rd = 0;
    chk("R8 event kept through clear", status, 8'h68);
    cts_n = 1; dcd_n = 1; settle();
    do_read(s);
    chk("R8 cleanup", status, 8'hF0);
  endtask

  task automatic t_irq();
    logic [7:0] s;
    dsr_n = 0; settle();
    chk("R9 irq off when disabled", {7'd0, irq}, 8'd0);
    msi_en = 1; #1;
    chk("R9 irq on", {7'd0, irq}, 8'd1);
    do_read(s);
    chk("R9 irq drops after read", {7'd0, irq}, 8'd0);
    dsr_n = 1; settle(); do_read(s); msi_en = 0;
  endtask

  task automatic t_loop();
    logic [7:0] s;
    loop_en = 1; settle(); do_read(s);
    cts_n = 0; ri_n = 0; dcd_n = 0; settle();
    chk("R10 pins ignored", status, 8'hF0);
    lb_rts = 0; settle();
    chk("R10 rts to cts", status, 8'hE1);
    do_read(s);
    lb_out2 = 0; settle();
    chk("R10 out2 to dcd", status, 8'h68);
    do_read(s);
    lb_dtr = 0; lb_out1 = 0; settle();
    chk("R10 dtr to dsr", status, 8'h02);
    do_read(s);
    lb_out1 = 1; settle();
    chk("R10 out1 to ri", status, 8'h44);
    do_read(s);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_layout();
    t_ring();
    t_collide();
    t_irq();
    t_loop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule